// File: doc/BRIEF.md
# Configurable-frame UART transmitter

This block turns bytes from a transmit FIFO into asynchronous serial frames on a single line. Whenever it is idle and the FIFO holds data, it pops one byte, samples the line-control byte and the clock divisor, and shifts the frame out. A frame is a low start bit, eight data bits least significant first, an optional parity bit, and one or two high stop bits. Each bit lasts the divisor value in system clocks, with no oversampling. For example, a 24 MHz clock with a divisor of 208 gives about 115200 baud.

The FIFO presents its head byte while it is not empty. When more data is queued, frames follow one another with no idle time between them. When the last stop bit ends and the FIFO is empty, the block raises a one-cycle completion pulse, and its empty indication goes high. A synchronous abort input drops the frame in flight at once and returns the line to idle. It is meant for soft reset.

Top module: `uart_tx_serializer`

## Requirements
- R1: After reset, with no data queued, the line is high, tx_empty_o is high, and tx_done_o and fifo_pop_o are low.
- R2: A frame is one low start bit, then data bits 0 through 7 in that order, then the parity bit when parity is enabled, then the stop bits at high level. The start bit appears on tx_o in the cycle after the pop.
- R3: ctrl_i[3:1] selects parity. 000 is even parity, so the parity bit is the XOR of the data bits. 001 is odd parity, so the parity bit is the inverted XOR. 111 and every other code send no parity bit.
- R4: ctrl_i[0] = 1 sends two stop bits, and ctrl_i[0] = 0 sends one.
- R5: Every bit of a frame lasts exactly divisor_i system clocks. A divisor of 0 is treated as 1.
- R6: The block pops once per frame, and only when the FIFO is not empty. If data is queued when a frame's last stop bit ends, the next start bit follows in the very next cycle with no idle gap.
- R7: tx_done_o pulses high for one cycle in the cycle after the last stop bit ends, and only when the FIFO is empty then. tx_empty_o is high exactly when no frame is in flight and the FIFO is empty.
- R8: ctrl_i and divisor_i are sampled when a frame starts. Changes made during a frame apply from the next frame onward.
- R9: abort_i returns the line high in the next cycle and abandons the frame in flight without a completion pulse. No frame starts in a cycle where abort_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| abort_i | input | 1 | Synchronous cancel of the frame in flight |
| ctrl_i | input | 8 | Line control: bit0 selects stop bit count, bits 3:1 select parity |
| divisor_i | input | 16 | Bit period in system clocks |
| fifo_empty_i | input | 1 | Transmit FIFO holds no data |
| fifo_data_i | input | 8 | Head byte of the transmit FIFO |
| fifo_pop_o | output | 1 | Remove the head byte; a frame starts |
| tx_o | output | 1 | Serial line, idles high |
| tx_empty_o | output | 1 | Idle with the FIFO empty |
| tx_done_o | output | 1 | One-cycle pulse when the FIFO drains after a frame |

## Verification
Two situations are hard to reach from the ports. The first is a change of format or divisor while a frame is in flight. The bench queues two bytes and rewrites ctrl_i and divisor_i a few cycles into the first frame. It then decodes the first frame with the old settings and the second with the new ones, and it times the handover cycle exactly. The second is an abort. The bench sends an all-zero byte so that a stale data bit would show as a low line, and it raises abort_i in the middle of the data bits. It also holds abort_i high while a byte waits in the FIFO, to show that no frame launches during the abort.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned FRAME_W = DATA_W + 4;  // start, data, parity, two stops
  localparam int unsigned LEFT_W  = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {PAR_NONE, PAR_EVEN, PAR_ODD} par_e;

  typedef struct packed {
    par_e par;
    logic two_stop;
  } fmt_t;

  function automatic fmt_t decode_ctrl(input logic [7:0] c);
    fmt_t f;
    f.two_stop = c[0];
    case (c[3:1])
      3'b000:  f.par = PAR_EVEN;
      3'b001:  f.par = PAR_ODD;
      default: f.par = PAR_NONE;
    endcase
    return f;
  endfunction
endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_q, cnt_q, div_eff;

  assign div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
  assign tick_o  = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= DIV_W'(1);
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      div_q <= div_eff;
      cnt_q <= div_eff - DIV_W'(1);
    end else if (run_i) begin
      if (tick_o) cnt_q <= div_q - DIV_W'(1);
      else        cnt_q <= cnt_q - DIV_W'(1);
    end
  end

  // R5: a bit never ends before the latched period has elapsed
  a_r5_tick_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && !clr_i && tick_o && div_q > DIV_W'(1)) |=> !tick_o);
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              launch_i,
  input  logic [DATA_W-1:0] data_i,
  input  fmt_t              fmt_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              end_o,
  output logic              tx_o
);
  logic [FRAME_W-2:0] shreg_q;
  logic [LEFT_W-1:0]  left_q, len_m1;
  logic [FRAME_W-1:0] frame;
  logic               par_bit, tx_q, busy_q;

  always_comb begin
    case (fmt_i.par)
      PAR_EVEN: par_bit = ^data_i;
      PAR_ODD:  par_bit = ~^data_i;
      default:  par_bit = 1'b1;  // slot becomes a stop bit
    endcase
    frame  = {2'b11, par_bit, data_i, 1'b0};
    len_m1 = LEFT_W'(DATA_W + 1) + LEFT_W'(fmt_i.par != PAR_NONE) + LEFT_W'(fmt_i.two_stop);
  end

  assign end_o  = busy_q && tick_i && (left_q == '0);
  assign busy_o = busy_q;
  assign tx_o   = tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      tx_q    <= 1'b1;
      left_q  <= '0;
      shreg_q <= '1;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      tx_q   <= 1'b1;
    end else if (launch_i) begin
      busy_q  <= 1'b1;
      tx_q    <= frame[0];
      shreg_q <= frame[FRAME_W-1:1];
      left_q  <= len_m1;
    end else if (busy_q && tick_i) begin
      if (left_q == '0) begin
        busy_q <= 1'b0;
        tx_q   <= 1'b1;
      end else begin
        tx_q    <= shreg_q[0];
        shreg_q <= {1'b1, shreg_q[FRAME_W-2:1]};
        left_q  <= left_q - LEFT_W'(1);
      end
    end
  end

  // R2: a launch always drives the start bit low in the next cycle
  a_r2_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_i && !abort_i) |=> !tx_o);
  // R2: the last bit of every frame is a stop bit
  a_r2_stop_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> tx_o);
endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
  import uart_tx_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic [7:0]        ctrl_i,
  input  logic [DIV_W-1:0]  divisor_i,
  input  logic              fifo_empty_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  output logic              fifo_pop_o,
  output logic              tx_o,
  output logic              tx_empty_o,
  output logic              tx_done_o
);
  logic busy, frame_end, tick, launch, done_q;

  assign launch     = !abort_i && !fifo_empty_i && (!busy || frame_end);
  assign fifo_pop_o = launch;
  assign tx_empty_o = !busy && fifo_empty_i;
  assign tx_done_o  = done_q;

  uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (abort_i),
    .load_i (launch),
    .run_i  (busy),
    .div_i  (divisor_i),
    .tick_o (tick)
  );

  uart_tx_frame u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .abort_i  (abort_i),
    .launch_i (launch),
    .data_i   (fifo_data_i),
    .fmt_i    (decode_ctrl(ctrl_i)),
    .tick_i   (tick),
    .busy_o   (busy),
    .end_o    (frame_end),
    .tx_o     (tx_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= frame_end && fifo_empty_i && !abort_i;
  end

  // R6: never pop an empty FIFO
  a_r6_pop_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> !fifo_empty_i);
  // R9: abort idles the line with no completion
  a_r9_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (tx_o && !tx_done_o));
  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |=> !tx_done_o);
  // R7: empty indication implies an idle line
  a_r7_empty_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> tx_o);
endmodule

// File: tb/uart_tx_serializer_bench.sv
module uart_tx_serializer_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, abort = 1'b0;
  logic [7:0]  ctrl = 8'h0E;
  logic [15:0] div = 16'd2;
  logic [7:0]  mem [64];
  int wr = 0, rd = 0;
  logic fifo_empty, pop, tx, tx_empty, tx_done;
  logic [7:0] fifo_data;
  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign fifo_empty = (wr == rd);
  assign fifo_data  = mem[rd % 64];
  always @(posedge clk) if (pop) rd <= rd + 1;

  uart_tx_serializer u_uart_tx_serializer (
    .clk_i(clk), .rst_ni(rst_n), .abort_i(abort), .ctrl_i(ctrl), .divisor_i(div),
    .fifo_empty_i(fifo_empty), .fifo_data_i(fifo_data), .fifo_pop_o(pop),
    .tx_o(tx), .tx_empty_o(tx_empty), .tx_done_o(tx_done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input logic [7:0] b);
    mem[wr % 64] = b;
    wr++;
  endtask

  task automatic wait_start();
    int n = 0;
    while (tx !== 1'b0 && n < 200) begin @(negedge clk); n++; end
    chk(tx === 1'b0, "R6 start seen", int'(tx), 0);
  endtask

  // Called at the negedge of the first start-bit cycle; returns at the frame's end cycle.
  task automatic recv(input logic [7:0] b, input logic [7:0] c, input int d_in, input bit last);
    int d, len, pos, tgt;
    logic [11:0] exp;
    logic pb;
    bit has_par;
    d = (d_in == 0) ? 1 : d_in;
    has_par = (c[3:1] == 3'b000) || (c[3:1] == 3'b001);
    pb = (c[3:1] == 3'b000) ? ^b : ~^b;
    len = 10 + int'(has_par) + int'(c[0]);
    exp = has_par ? {2'b11, pb, b, 1'b0} : {3'b111, b, 1'b0};
    pos = 0;
    for (int k = 0; k < len; k++) begin
      tgt = k * d + d / 2;
      repeat (tgt - pos) @(negedge clk);
      pos = tgt;
      if (k == 0) chk(tx_empty === 1'b0, "R7 empty low in frame", int'(tx_empty), 0);
      if (k == 0)                 chk(tx === exp[k], "R2 start bit", int'(tx), int'(exp[k]));
      else if (k <= 8)            chk(tx === exp[k], "R2 data bit", int'(tx), int'(exp[k]));
      else if (k == 9 && has_par) chk(tx === exp[k], "R3 parity bit", int'(tx), int'(exp[k]));
      else                        chk(tx === 1'b1, "R4 stop bit", int'(tx), 1);
    end
    repeat (len * d - pos) @(negedge clk);
    chk(tx_done === last, "R7 done at drain", int'(tx_done), int'(last));
    if (last) begin
      chk(tx === 1'b1, "R5 frame length idle", int'(tx), 1);
      chk(tx_empty === 1'b1, "R7 empty after drain", int'(tx_empty), 1);
    end else begin
      chk(tx === 1'b0, "R6 back-to-back start", int'(tx), 0);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    logic [2:0] codes [4];
    int divs [5];
    int idx = 0;
    codes = '{3'b000, 3'b001, 3'b111, 3'b010};
    divs  = '{1, 2, 3, 5, 0};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(tx === 1'b1, "R1 line idle", int'(tx), 1);
    chk(tx_empty === 1'b1, "R1 empty", int'(tx_empty), 1);
    chk(tx_done === 1'b0, "R1 done low", int'(tx_done), 0);
    chk(pop === 1'b0, "R1 pop low", int'(pop), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(tx === 1'b1, "R1 line idle after reset", int'(tx), 1);

    // R2 R3 R4 R5 R6 R7: sweep of formats and divisors
    for (int ci = 0; ci < 4; ci++)
      for (int s = 0; s < 2; s++)
        for (int di = 0; di < 5; di++) begin
          logic [7:0] b0, b1, c;
          b0 = 8'(idx * 37 + 5);
          b1 = 8'(idx * 91 + 200);
          idx++;
          c = {4'b0, codes[ci], 1'(s)};
          ctrl = c;
          div = 16'(divs[di]);
          push(b0); push(b1);
          @(negedge clk);
          chk(tx === 1'b0, "R6 start one cycle after pop", int'(tx), 0);
          recv(b0, c, divs[di], 1'b0);
          recv(b1, c, divs[di], 1'b1);
          @(negedge clk);
          chk(tx_done === 1'b0, "R7 done single cycle", int'(tx_done), 0);
          chk(rd == wr, "R6 one pop per frame", rd, wr);
          repeat (2) @(negedge clk);
        end

    // R8: mid-frame change of format and divisor
    ctrl = 8'h0E; div = 16'd3;
    push(8'hA5); push(8'h3C);
    @(negedge clk);
    fork
      begin
        recv(8'hA5, 8'h0E, 3, 1'b0);
        recv(8'h3C, 8'h03, 2, 1'b1);
      end
      begin
        repeat (4) @(negedge clk);
        ctrl = 8'h03; div = 16'd2;
      end
    join
    repeat (3) @(negedge clk);

    // R9: abort in the middle of a frame of zero data bits
    ctrl = 8'h00; div = 16'd4;
    push(8'h00);
    wait_start();
    repeat (10) @(negedge clk);
    chk(tx === 1'b0, "R9 line low before abort", int'(tx), 0);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(tx === 1'b1, "R9 line high after abort", int'(tx), 1);
    begin
      bit low_seen = 0, done_seen = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (tx !== 1'b1) low_seen = 1;
        if (tx_done !== 1'b0) done_seen = 1;
      end
      chk(!low_seen, "R9 nothing output after abort", int'(low_seen), 0);
      chk(!done_seen, "R9 no done after abort", int'(done_seen), 0);
    end
    chk(tx_empty === 1'b1, "R9 empty after abort", int'(tx_empty), 1);

    // R9: no launch while abort is held
    abort = 1'b1;
    push(8'h5A);
    repeat (5) @(negedge clk);
    chk(tx === 1'b1, "R9 held abort blocks start", int'(tx), 1);
    chk(rd != wr, "R9 byte still queued", rd, wr - 1);
    abort = 1'b0;
    @(negedge clk);
    chk(tx === 1'b0, "R6 start after abort release", int'(tx), 0);
    recv(8'h5A, 8'h00, 4, 1'b1);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule